// File: doc/BRIEF.md
# Serial EEPROM Word Controller

This block is a bit-serial master for a small nonvolatile memory reached over three wires: a select line, a serial clock and a data line out, plus one data line in. The memory holds 64 words of 16 bits. A single request reads one word, or writes one word through a fixed four-step sequence. The caller presents an address, and write data for a write, pulses a request for one cycle, and waits for a one-cycle completion pulse. The block stays busy for the whole sequence.

Every command session starts with select raised and two clock pulses. The first carries a zero and the second carries the start bit, a one. An eight-bit command follows, most significant bit first. The top two bits of the command hold the opcode and the low six bits hold the word address. A write runs enable, erase, program and disable back to back. After erase and after program the controller drops select and holds it low for a programmable wait. It then closes the operation with a single clock event under select. The serial clock rate and the wait length are parameters.

Top module: `serial_eeprom_word_ctrl`

## Requirements
- R1: After reset and whenever the block is idle, select and serial clock are low; busy and done are low after reset.
- R2: Every command session begins with select rising, one clock pulse with data 0, then one clock pulse with data 1, before any command bit.
- R3: Command bits go out MSB first, one per clock pulse, with data held steady while the clock is high. Read is `10` followed by the address, program is `01` followed by the address, erase is `11` followed by the address, enable is 0x30 and disable is 0x00.
- R4: A read sends its command, then gives 16 more clock pulses and samples the data input while the clock is high, high bit first. Select then drops, and the word appears on the read data output when done pulses.
- R5: A write request produces exactly four sessions in this order: enable, erase of the target, program of the target with 16 data bits MSB first after the command, disable.
- R6: After an erase or program session, select stays low for at least WAIT_CYCLES clock cycles. The next session then carries exactly one clock pulse.
- R7: Enable and disable sessions carry exactly 10 clock pulses (preamble and command) and are followed by no programming wait.
- R8: Busy rises in the cycle after an accepted request. Done is high for exactly one cycle, in the first cycle in which busy is low again.
- R9: A read or write request that arrives while busy is ignored: it starts no session and leaves memory contents unchanged.
- R10: When read and write are requested in the same idle cycle, only the read is performed.
- R11: Each high phase of the serial clock lasts CLK_DIV cycles, and the clock only toggles while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqRead | input | 1 | One-cycle read request |
| reqWrite | input | 1 | One-cycle write request |
| addr | input | ADDR_W | Word address, captured with the request |
| wrData | input | DATA_W | Word to write, captured with the request |
| rdData | output | DATA_W | Last word read, valid from done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| memSel | output | 1 | Memory select |
| memClk | output | 1 | Serial clock |
| memDout | output | 1 | Serial data to memory |
| memDin | input | 1 | Serial data from memory |

## Verification
The bench builds the block with CLK_DIV of 2 and WAIT_CYCLES of 20. With these values a full write sequence takes a few hundred cycles, so every one of the 64 addresses can be written and read back, and the memory's initial contents can be read first. A behavioural memory stub in the bench decodes every session bit by bit and measures the select-low time after erase and program. All-zero and all-one words at the two end addresses cover the extremes of the data path. The bench also raises requests in the middle of a sequence and requests both operations in the same cycle.

// File: rtl/eeword_pkg.sv
`timescale 1ns/1ps
package eeword_pkg;

  typedef enum logic [2:0] {
    OP_READ,
    OP_WEN,
    OP_ERASE,
    OP_WRITE,
    OP_WDS
  } opKind_t;

  typedef enum logic [1:0] {
    DO_ZERO,
    DO_ONE,
    DO_SHIFT
  } doutSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     latchReq;
    logic     pulseGo;
    logic     loadCmd;
    logic     loadWord;
    logic     shiftEn;
    logic     sampleEn;
    logic     bitsLoad;
    logic     bitsWord;
    logic     waitGo;
    logic     waitLong;
    logic     captureRd;
    doutSel_t doutSel;
    opKind_t  op;
  } strobe_t;

endpackage

// File: rtl/eeword_datapath.sv
`timescale 1ns/1ps
module eeword_datapath
  import eeword_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int CLK_DIV     = 4,
  parameter int WAIT_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrDataIn,
  input  logic              memDin,
  output logic              memDout,
  output logic              memClk,
  output logic [DATA_W-1:0] rdData,
  output logic              pulseEnd,
  output logic              bitsLast,
  output logic              waitEnd
);

  localparam int CMD_W    = ADDR_W + 2;
  localparam int PAD_W    = DATA_W - CMD_W;
  localparam int DIV_W    = $clog2(CLK_DIV + 1);
  localparam int WAIT_MAX = (WAIT_CYCLES > CLK_DIV) ? WAIT_CYCLES : CLK_DIV;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int BIT_W    = $clog2(DATA_W);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

  phase_t            phase;
  logic [DIV_W-1:0]  divCnt;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wrReg;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] rdShift;
  logic [BIT_W-1:0]  bitCnt;
  logic              waitBusy;
  logic [WAIT_W-1:0] waitCnt;
  logic [CMD_W-1:0]  cmdByte;

  // serial clock engine: low phase, high phase, back to idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      divCnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (st.pulseGo) begin
          phase  <= PH_LOW;
          divCnt <= DIV_W'(CLK_DIV - 1);
        end
        PH_LOW: if (divCnt == '0) begin
          phase  <= PH_HIGH;
          divCnt <= DIV_W'(CLK_DIV - 1);
        end else begin
          divCnt <= divCnt - 1'b1;
        end
        PH_HIGH: if (divCnt == '0) begin
          phase <= PH_IDLE;
        end else begin
          divCnt <= divCnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign memClk   = (phase == PH_HIGH);
  assign pulseEnd = (phase == PH_HIGH) && (divCnt == '0);

  // request capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      wrReg   <= '0;
    end else if (st.latchReq) begin
      addrReg <= addrIn;
      wrReg   <= wrDataIn;
    end
  end

  // opcode in the top two bits, address below
  always_comb begin
    case (st.op)
      OP_READ:  cmdByte = {2'b10, addrReg};
      OP_WRITE: cmdByte = {2'b01, addrReg};
      OP_ERASE: cmdByte = {2'b11, addrReg};
      OP_WEN:   cmdByte = {2'b00, 2'b11, {(ADDR_W-2){1'b0}}};
      default:  cmdByte = '0;
    endcase
  end

  // outgoing shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (st.loadWord) begin
      shReg <= wrReg;
    end else if (st.loadCmd) begin
      shReg <= {cmdByte, {PAD_W{1'b0}}};
    end else if (st.shiftEn && pulseEnd) begin
      shReg <= {shReg[DATA_W-2:0], 1'b0};
    end
  end

  always_comb begin
    case (st.doutSel)
      DO_ONE:   memDout = 1'b1;
      DO_SHIFT: memDout = shReg[DATA_W-1];
      default:  memDout = 1'b0;
    endcase
  end

  // incoming shift register, sampled in the last high cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdShift <= '0;
      rdData  <= '0;
    end else begin
      if (st.sampleEn && pulseEnd) rdShift <= {rdShift[DATA_W-2:0], memDin};
      if (st.captureRd) rdData <= rdShift;
    end
  end

  // bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (st.bitsLoad) begin
      bitCnt <= st.bitsWord ? BIT_W'(DATA_W - 1) : BIT_W'(CMD_W - 1);
    end else if (pulseEnd && bitCnt != '0) begin
      bitCnt <= bitCnt - 1'b1;
    end
  end

  assign bitsLast = (bitCnt == '0);

  // wait timer: long programming wait or short inter-session gap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitBusy <= 1'b0;
      waitCnt  <= '0;
    end else if (waitBusy) begin
      if (waitCnt == '0) waitBusy <= 1'b0;
      else               waitCnt  <= waitCnt - 1'b1;
    end else if (st.waitGo) begin
      waitBusy <= 1'b1;
      waitCnt  <= st.waitLong ? WAIT_W'(WAIT_CYCLES - 1) : WAIT_W'(CLK_DIV - 1);
    end
  end

  assign waitEnd = waitBusy && (waitCnt == '0);

endmodule

// File: rtl/eeword_ctrl.sv
`timescale 1ns/1ps
module eeword_ctrl
  import eeword_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqRead,
  input  logic    reqWrite,
  input  logic    pulseEnd,
  input  logic    bitsLast,
  input  logic    waitEnd,
  output strobe_t st,
  output logic    memSel,
  output logic    busy,
  output logic    done
);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE0, S_PRE1, S_CMD, S_RDBITS, S_WRBITS, S_PWAIT, S_EVT, S_GAP
  } state_t;

  state_t  state, nextState;
  opKind_t opReg, nextOp;
  logic    doneNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      opReg <= OP_READ;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      opReg <= nextOp;
      done  <= doneNext;
    end
  end

  assign busy = (state != S_IDLE);

  always_comb begin
    st         = '0;
    st.op      = opReg;
    st.doutSel = DO_ZERO;
    memSel     = 1'b0;
    nextState  = state;
    nextOp     = opReg;
    doneNext   = 1'b0;
    case (state)
      S_IDLE: begin
        if (reqRead) begin
          st.latchReq = 1'b1;
          nextOp      = OP_READ;
          nextState   = S_PRE0;
        end else if (reqWrite) begin
          st.latchReq = 1'b1;
          nextOp      = OP_WEN;
          nextState   = S_PRE0;
        end
      end
      S_PRE0: begin
        memSel     = 1'b1;
        st.pulseGo = 1'b1;
        if (pulseEnd) nextState = S_PRE1;
      end
      S_PRE1: begin
        memSel     = 1'b1;
        st.pulseGo = 1'b1;
        st.doutSel = DO_ONE;
        if (pulseEnd) begin
          st.loadCmd  = 1'b1;
          st.bitsLoad = 1'b1;
          nextState   = S_CMD;
        end
      end
      S_CMD: begin
        memSel     = 1'b1;
        st.pulseGo = 1'b1;
        st.doutSel = DO_SHIFT;
        st.shiftEn = 1'b1;
        if (pulseEnd && bitsLast) begin
          case (opReg)
            OP_READ: begin
              st.bitsLoad = 1'b1;
              st.bitsWord = 1'b1;
              nextState   = S_RDBITS;
            end
            OP_WRITE: begin
              st.loadWord = 1'b1;
              st.bitsLoad = 1'b1;
              st.bitsWord = 1'b1;
              nextState   = S_WRBITS;
            end
            OP_ERASE: nextState = S_PWAIT;
            default:  nextState = S_GAP;
          endcase
        end
      end
      S_RDBITS: begin
        memSel      = 1'b1;
        st.pulseGo  = 1'b1;
        st.doutSel  = DO_ONE;
        st.sampleEn = 1'b1;
        if (pulseEnd && bitsLast) nextState = S_GAP;
      end
      S_WRBITS: begin
        memSel     = 1'b1;
        st.pulseGo = 1'b1;
        st.doutSel = DO_SHIFT;
        st.shiftEn = 1'b1;
        if (pulseEnd && bitsLast) nextState = S_PWAIT;
      end
      S_PWAIT: begin
        st.waitGo   = 1'b1;
        st.waitLong = 1'b1;
        if (waitEnd) nextState = S_EVT;
      end
      S_EVT: begin
        memSel     = 1'b1;
        st.pulseGo = 1'b1;
        if (pulseEnd) nextState = S_GAP;
      end
      S_GAP: begin
        st.waitGo = 1'b1;
        if (waitEnd) begin
          case (opReg)
            OP_READ: begin
              st.captureRd = 1'b1;
              doneNext     = 1'b1;
              nextState    = S_IDLE;
            end
            OP_WEN: begin
              nextOp    = OP_ERASE;
              nextState = S_PRE0;
            end
            OP_ERASE: begin
              nextOp    = OP_WRITE;
              nextState = S_PRE0;
            end
            OP_WRITE: begin
              nextOp    = OP_WDS;
              nextState = S_PRE0;
            end
            default: begin
              doneNext  = 1'b1;
              nextState = S_IDLE;
            end
          endcase
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/serial_eeprom_word_ctrl.sv
`timescale 1ns/1ps
module serial_eeprom_word_ctrl
  import eeword_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int CLK_DIV     = 4,
  parameter int WAIT_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqRead,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              memSel,
  output logic              memClk,
  output logic              memDout,
  input  logic              memDin
);

  strobe_t st;
  logic    pulseEnd;
  logic    bitsLast;
  logic    waitEnd;

  eeword_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqRead  (reqRead),
    .reqWrite (reqWrite),
    .pulseEnd (pulseEnd),
    .bitsLast (bitsLast),
    .waitEnd  (waitEnd),
    .st       (st),
    .memSel   (memSel),
    .busy     (busy),
    .done     (done)
  );

  eeword_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CLK_DIV     (CLK_DIV),
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .addrIn   (addr),
    .wrDataIn (wrData),
    .memDin   (memDin),
    .memDout  (memDout),
    .memClk   (memClk),
    .rdData   (rdData),
    .pulseEnd (pulseEnd),
    .bitsLast (bitsLast),
    .waitEnd  (waitEnd)
  );

endmodule

// File: rtl/eeword_checker.sv
`timescale 1ns/1ps
module eeword_checker #(
  parameter int CLK_DIV = 4
) (
  input logic clk,
  input logic rstN,
  input logic reqRead,
  input logic reqWrite,
  input logic busy,
  input logic done,
  input logic memSel,
  input logic memClk,
  input logic memDout
);

  logic [15:0] highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                highRun <= '0;
    else if (!memClk)         highRun <= '0;
    else if (highRun != '1)   highRun <= highRun + 1'b1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memSel && !memClk));

  a_r11_clock_under_select: assert property (@(posedge clk) disable iff (!rstN)
    memClk |-> memSel);

  a_r11_high_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memClk) |-> (highRun >= 16'(CLK_DIV)));

  a_r3_data_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (memClk && $past(memClk)) |-> $stable(memDout));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r9_start_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqRead || reqWrite));

endmodule

bind serial_eeprom_word_ctrl eeword_checker #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqRead  (reqRead),
  .reqWrite (reqWrite),
  .busy     (busy),
  .done     (done),
  .memSel   (memSel),
  .memClk   (memClk),
  .memDout  (memDout)
);

// File: tb/serial_eeprom_word_ctrl_bench.sv
`timescale 1ns/1ps
module serial_eeprom_word_ctrl_bench;

  localparam int T      = 8;
  localparam int CDIV   = 2;
  localparam int WAITC  = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqRead = 1'b0;
  logic        reqWrite = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        busy, done, memSel, memClk, memDout;
  logic        memDin = 1'b0;

  int total = 0;
  int bad = 0;

  always #(T/2) clk = ~clk;

  serial_eeprom_word_ctrl #(
    .ADDR_W(6), .DATA_W(16), .CLK_DIV(CDIV), .WAIT_CYCLES(WAITC)
  ) u_serial_eeprom_word_ctrl (
    .clk(clk), .rstN(rstN), .reqRead(reqRead), .reqWrite(reqWrite),
    .addr(addr), .wrData(wrData), .rdData(rdData), .busy(busy), .done(done),
    .memSel(memSel), .memClk(memClk), .memDout(memDout), .memDin(memDin)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory stub ----------------
  logic [15:0] mem [64];
  logic [15:0] shadow [64];
  logic        wen = 1'b0;
  logic [31:0] sess = '0;
  int          sessN = 0;
  logic        rdAct = 1'b0;
  logic [5:0]  rdAddr = '0;
  int          rdIdx = 0;
  logic        expectEvt = 1'b0;
  time         tFall = 0;
  logic [7:0]  opLog [16];
  int          opCnt = 0;
  time         tRise = 0, tFallClk = 0;
  time         minHigh = 1000000, minLow = 1000000;

  function automatic logic [15:0] initVal(input int i);
    return 16'(i * 16'h0101) ^ 16'h5A3C;
  endfunction

  always @(posedge memSel) begin
    if (expectEvt)
      chk(($time - tFall) >= WAITC * T, "R6", "select low time",
          32'(($time - tFall) / T), WAITC);
    sess  = '0;
    sessN = 0;
    rdAct = 1'b0;
  end

  always @(posedge memClk) begin
    tRise = $time;
    if (tFallClk != 0 && ($time - tFallClk) < minLow) minLow = $time - tFallClk;
    if (memSel) begin
      sess  = {sess[30:0], memDout};
      sessN = sessN + 1;
      if (sessN == 10 && sess[7:6] == 2'b10 && !expectEvt) begin
        rdAct  = 1'b1;
        rdAddr = sess[5:0];
        rdIdx  = 0;
      end
    end
  end

  always @(negedge memClk) begin
    tFallClk = $time;
    if (($time - tRise) < minHigh) minHigh = $time - tRise;
    if (rdAct && rdIdx < 16) begin
      memDin = mem[rdAddr][15 - rdIdx];
      rdIdx  = rdIdx + 1;
    end
  end

  always @(negedge memSel) begin
    logic [7:0] cmd;
    rdAct = 1'b0;
    if (expectEvt) begin
      chk(sessN == 1, "R6", "closing event pulse count", sessN, 1);
      expectEvt = 1'b0;
    end else if (sessN != 10 && sessN != 26) begin
      chk(1'b0, "R7", "session length", sessN, 10);
    end else begin
      chk({sess[sessN-1], sess[sessN-2]} == 2'b01, "R2", "preamble bits",
          {sess[sessN-1], sess[sessN-2]}, 2'b01);
      cmd = sess[(sessN-10) +: 8];
      if (opCnt < 16) opLog[opCnt] = cmd;
      opCnt = opCnt + 1;
      if (sessN == 10) begin
        if (cmd == 8'h30 || cmd == 8'h00) begin
          chk(1'b1, "R7", "enable/disable length", sessN, 10);
          wen = (cmd == 8'h30);
        end else if (cmd[7:6] == 2'b11) begin
          chk(wen, "R5", "erase while enabled", wen, 1);
          mem[cmd[5:0]] = 16'hFFFF;
          expectEvt = 1'b1;
          tFall = $time;
        end else begin
          chk(1'b0, "R3", "short session command", cmd, 8'h30);
        end
      end else begin
        if (cmd[7:6] == 2'b01) begin
          chk(wen, "R5", "program while enabled", wen, 1);
          mem[cmd[5:0]] = sess[15:0];
          expectEvt = 1'b1;
          tFall = $time;
        end else if (cmd[7:6] != 2'b10) begin
          chk(1'b0, "R3", "long session command", cmd, 8'h80);
        end
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done && !busy, "R8", {req, " done with busy low"}, {done, busy}, 2'b10);
    @(negedge clk);
    chk(!done, "R8", "done single cycle", done, 0);
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [15:0] d);
    opCnt = 0;
    @(negedge clk);
    addr = a; wrData = d; reqWrite = 1'b1;
    @(negedge clk);
    reqWrite = 1'b0;
    chk(busy, "R8", "busy after write request", busy, 1);
    waitDone("write");
    shadow[a] = d;
    chk(opCnt == 4, "R5", "write session count", opCnt, 4);
    chk(opLog[0] == 8'h30, "R5", "step 1 enable", opLog[0], 8'h30);
    chk(opLog[1] == {2'b11, a}, "R5", "step 2 erase", opLog[1], {2'b11, a});
    chk(opLog[2] == {2'b01, a}, "R5", "step 3 program", opLog[2], {2'b01, a});
    chk(opLog[3] == 8'h00, "R5", "step 4 disable", opLog[3], 8'h00);
    chk(mem[a] == d, "R5", "stored word", mem[a], d);
  endtask

  task automatic doRead(input logic [5:0] a, input bit both);
    opCnt = 0;
    @(negedge clk);
    addr = a; wrData = 16'hDEAD; reqRead = 1'b1; reqWrite = both;
    @(negedge clk);
    reqRead = 1'b0; reqWrite = 1'b0;
    chk(busy, "R8", "busy after read request", busy, 1);
    waitDone("read");
    chk(opCnt == 1, both ? "R10" : "R4", "read session count", opCnt, 1);
    chk(opLog[0] == {2'b10, a}, "R3", "read command", opLog[0], {2'b10, a});
    chk(rdData == shadow[a], both ? "R10" : "R4", "read data", rdData, shadow[a]);
  endtask

  initial begin
    #(T * 200000);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i]    = initVal(i);
      shadow[i] = initVal(i);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy, "R1", "busy in reset", busy, 0);
    chk(!done, "R1", "done in reset", done, 0);
    chk(!memSel, "R1", "select in reset", memSel, 0);
    chk(!memClk, "R1", "clock in reset", memClk, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!memSel && !memClk && !busy && !done, "R1", "idle after reset",
        {memSel, memClk, busy, done}, 0);

    // R4: read the initial contents everywhere
    for (int a = 0; a < 64; a++) doRead(6'(a), 1'b0);

    // R5/R6: write every word, extremes at the end addresses
    for (int a = 0; a < 64; a++) begin
      logic [15:0] d;
      d = (a == 0) ? 16'h0000 : (a == 63) ? 16'hFFFF : 16'(a * 16'h9E37 + 16'h1357);
      doWrite(6'(a), d);
    end
    for (int a = 0; a < 64; a++) doRead(6'(a), 1'b0);

    // R9: requests during a write are ignored
    opCnt = 0;
    @(negedge clk);
    addr = 6'd5; wrData = 16'h1111; reqWrite = 1'b1;
    @(negedge clk);
    reqWrite = 1'b0;
    repeat (30) @(negedge clk);
    addr = 6'd7; reqRead = 1'b1;
    @(negedge clk);
    reqRead = 1'b0;
    repeat (60) @(negedge clk);
    addr = 6'd9; wrData = 16'hBEEF; reqWrite = 1'b1;
    @(negedge clk);
    reqWrite = 1'b0;
    waitDone("write under load");
    shadow[5] = 16'h1111;
    chk(opCnt == 4, "R9", "sessions during busy write", opCnt, 4);
    chk(opLog[2] == {2'b01, 6'd5}, "R9", "programmed address", opLog[2], {2'b01, 6'd5});
    repeat (5) @(negedge clk);
    chk(!busy && !memSel, "R9", "nothing queued", {busy, memSel}, 0);
    chk(mem[9] == shadow[9], "R9", "ignored write left word", mem[9], shadow[9]);
    doRead(6'd5, 1'b0);
    doRead(6'd9, 1'b0);

    // R10: both requests in one cycle
    doRead(6'd12, 1'b1);
    chk(mem[12] == shadow[12], "R10", "no write performed", mem[12], shadow[12]);

    // R11: clock phase widths
    chk(minHigh >= CDIV * T, "R11", "min high width", 32'(minHigh), CDIV * T);
    chk(minLow >= CDIV * T, "R11", "min low width", 32'(minLow), CDIV * T);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule